// File: doc/BRIEF.md
# Parity-Checked SRAM Word Port

This block sits between a 32-bit system bus port and one word-organized SRAM bank. Beside every data word it keeps one even-parity bit per byte lane. A word of four lanes therefore carries four parity bits, and two flipped bits in different bytes are both seen. The SRAM itself stays outside the block. The block drives the memory's enable, write, address and data pins and takes back the registered read word together with its parity bits.

Reads are checked. Writes that update only some byte lanes become a read-merge-write: the old word is read and checked, then the merged word is written with fresh parity on all lanes. When that check fails, the write is still committed and the error is reported. Writes with all four strobes set replace the word outright and skip the check. A per-bank enable input switches error reporting on or off. Parity bits are generated on every write whatever its setting.

Each accepted transfer is answered one cycle after acceptance by a single-cycle ready. The error flag can be high only in that ready cycle. The requester holds its request fields until ready.

Top module: `sram_parity_port`

## Requirements
- R1: While reset is active, and in the cycles before the synchronized reset releases, bus_ready, bus_err and mem_en are 0, even with bus_req high.
- R2: A read is accepted with one memory read in its acceptance cycle. In the next cycle bus_ready is 1 and bus_rdata holds the stored word.
- R3: A write with bus_strb = 4'b1111 issues exactly one memory write and no read, in its acceptance cycle. Stored parity bit i equals the XOR of data bits 8i+7..8i. bus_ready follows in the next cycle with bus_err 0, even when the old contents were corrupt.
- R4: A write with any strobe bit clear issues one memory read in its acceptance cycle and one write in the next cycle, together with bus_ready. In that write, byte i (bits 8i+7..8i) comes from bus_wdata when bus_strb[i] is 1 and from the old word otherwise.
- R5: With par_en = 1, a read raises bus_err together with bus_ready when any lane (8 data bits plus its parity bit) has an odd number of ones. This includes an error in a parity bit itself.
- R6: Two flipped bits located in two different byte lanes of one word are reported as an error on read.
- R7: A partial write whose old word fails the check (par_en = 1) raises bus_err and still commits the merged word with fresh parity, so a later read returns the merged data without error.
- R8: With par_en = 0, bus_err stays 0 on reads and partial writes of corrupt words. Parity is still written, so a later read with par_en = 1 reports no error.
- R9: bus_ready is high for exactly one cycle per transfer, exactly one cycle after acceptance. bus_err is never high without bus_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_en | input | 1 | Error reporting enable for this bank |
| bus_req | input | 1 | Transfer request, held until bus_ready |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_strb | input | DATA_W/8 | Byte-lane write strobes |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid with bus_ready on reads |
| bus_ready | output | 1 | Transfer completion, one cycle |
| bus_err | output | 1 | Parity error response, only with bus_ready |
| mem_en | output | 1 | SRAM access enable |
| mem_we | output | 1 | SRAM write enable |
| mem_addr | output | ADDR_W | SRAM word address |
| mem_wdata | output | DATA_W | SRAM write data |
| mem_wpar | output | DATA_W/8 | SRAM write parity, one bit per lane |
| mem_rdata | input | DATA_W | SRAM read data, one cycle after a read |
| mem_rpar | input | DATA_W/8 | SRAM read parity, one cycle after a read |

## Verification
The bench builds the block with ADDR_W = 4 and DATA_W = 32, which gives four lanes and a sixteen-word model array. The small address space lets the bench seed the whole SRAM model with zero words that already carry consistent parity. The bench corrupts stored bits directly in its model, in data lanes and in parity bits. This exposes single and dual-lane errors, checked and bypassed writes over bad words, and reporting with the enable on and off. Counting memory reads and writes per transfer separates full-word writes from read-merge-write without looking inside the design.

// File: rtl/sram_par_pkg.sv
package sram_par_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,  // waiting for a request
    ST_RD   = 2'd1,  // read data returning, respond
    ST_RMW  = 2'd2,  // old word returning, write merged word, respond
    ST_WR   = 2'd3   // full-word write done, respond
  } port_state_e;
endpackage

// File: rtl/sram_par_rst_sync.sv
module sram_par_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/sram_par_gen.sv
module sram_par_gen #(
  parameter int LANES = 4
) (
  input  logic [LANES*8-1:0] data,
  output logic [LANES-1:0]   par
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign par[i] = ^data[i*8 +: 8];
  end
endmodule

// File: rtl/sram_par_chk.sv
module sram_par_chk #(
  parameter int LANES = 4
) (
  input  logic [LANES*8-1:0] data,
  input  logic [LANES-1:0]   par,
  output logic               bad
);
  logic [LANES-1:0] syndrome;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign syndrome[i] = ^{par[i], data[i*8 +: 8]};
  end

  assign bad = |syndrome;
endmodule

// File: rtl/sram_par_merge.sv
module sram_par_merge #(
  parameter int LANES = 4
) (
  input  logic [LANES*8-1:0] old_word,
  input  logic [LANES*8-1:0] new_word,
  input  logic [LANES-1:0]   strb,
  output logic [LANES*8-1:0] merged
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign merged[i*8 +: 8] = strb[i] ? new_word[i*8 +: 8] : old_word[i*8 +: 8];
  end
endmodule

// File: rtl/sram_parity_port.sv
module sram_parity_port
  import sram_par_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  par_en,
  input  logic                  bus_req,
  input  logic                  bus_write,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W/8-1:0]   bus_strb,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  output logic                  bus_ready,
  output logic                  bus_err,
  output logic                  mem_en,
  output logic                  mem_we,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [DATA_W-1:0]     mem_wdata,
  output logic [DATA_W/8-1:0]   mem_wpar,
  input  logic [DATA_W-1:0]     mem_rdata,
  input  logic [DATA_W/8-1:0]   mem_rpar
);
  localparam int LANES = DATA_W / 8;

  logic              srst_n;
  port_state_e       state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [LANES-1:0]  strb_q;
  logic [DATA_W-1:0] wdata_q;
  logic              accept;
  logic              full_word;
  logic              in_rmw;
  logic              rd_bad;
  logic [DATA_W-1:0] merged;
  logic [DATA_W-1:0] wsrc;

  sram_par_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  assign accept    = srst_n && (state_q == ST_IDLE) && bus_req;
  assign full_word = &bus_strb;
  assign in_rmw    = (state_q == ST_RMW);

  // next-state process
  always_comb begin
    state_d = ST_IDLE;
    if (accept) begin
      if (!bus_write)     state_d = ST_RD;
      else if (full_word) state_d = ST_WR;
      else                state_d = ST_RMW;
    end
  end

  // state register
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  // request capture, enabled on acceptance
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      addr_q  <= '0;
      strb_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= bus_addr;
      strb_q  <= bus_strb;
      wdata_q <= bus_wdata;
    end
  end

  sram_par_merge #(.LANES(LANES)) u_merge (
    .old_word (mem_rdata),
    .new_word (wdata_q),
    .strb     (strb_q),
    .merged   (merged)
  );

  sram_par_chk #(.LANES(LANES)) u_chk (
    .data (mem_rdata),
    .par  (mem_rpar),
    .bad  (rd_bad)
  );

  assign wsrc = in_rmw ? merged : bus_wdata;

  sram_par_gen #(.LANES(LANES)) u_gen (
    .data (wsrc),
    .par  (mem_wpar)
  );

  // memory side: issue in the acceptance cycle, merged write in the RMW cycle
  assign mem_en    = accept || in_rmw;
  assign mem_we    = in_rmw || (accept && bus_write && full_word);
  assign mem_addr  = in_rmw ? addr_q : bus_addr;
  assign mem_wdata = wsrc;

  // bus response
  assign bus_ready = (state_q != ST_IDLE);
  assign bus_err   = par_en && rd_bad && ((state_q == ST_RD) || in_rmw);
  assign bus_rdata = mem_rdata;
endmodule

// File: rtl/sram_parity_port_chk.sv
module sram_parity_port_chk #(
  parameter int DATA_W = 32,
  parameter int LANES  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              par_en,
  input logic [LANES-1:0]  bus_strb,
  input logic              bus_ready,
  input logic              bus_err,
  input logic              mem_en,
  input logic              mem_we,
  input logic [DATA_W-1:0] mem_wdata,
  input logic [LANES-1:0]  mem_wpar
);
  AST_ERR_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> bus_ready); // R9

  AST_READY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready |=> !bus_ready); // R9

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !par_en |-> !bus_err); // R8

  AST_READ_THEN_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_we) |=> bus_ready); // R2

  AST_FULL_WR_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we && (&bus_strb)) |=> (bus_ready && !bus_err)); // R3

  AST_MERGE_WR_AT_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we && !(&bus_strb)) |-> bus_ready); // R4

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    AST_WPAR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && mem_we) |-> (mem_wpar[i] == ^mem_wdata[i*8 +: 8])); // R3
  end
endmodule

bind sram_parity_port sram_parity_port_chk #(.DATA_W(DATA_W), .LANES(LANES)) u_prop (
  .clk       (clk),
  .rst_n     (rst_n),
  .par_en    (par_en),
  .bus_strb  (bus_strb),
  .bus_ready (bus_ready),
  .bus_err   (bus_err),
  .mem_en    (mem_en),
  .mem_we    (mem_we),
  .mem_wdata (mem_wdata),
  .mem_wpar  (mem_wpar)
);

// File: tb/sram_parity_port_test.sv
`timescale 1ns/100ps
module sram_parity_port_test;
  localparam int AW = 4;
  localparam int DW = 32;

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [3:0]  strb;
    logic [31:0] wdata;
    logic [35:0] flip;   // {parity[3:0], data[31:0]} xor applied to stored word first
    logic        pen;
    logic [31:0] exp_rd;
    logic        exp_err;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 8'd1, 4'hF, 32'hA5A5_0F0F, 36'h0,           1'b1, 32'h0,         1'b0, 4'd3}, // R3
    '{1'b0, 8'd1, 4'h0, 32'h0,         36'h0,           1'b1, 32'hA5A5_0F0F, 1'b0, 4'd2}, // R2
    '{1'b1, 8'd2, 4'hF, 32'h1234_5678, 36'h0,           1'b1, 32'h0,         1'b0, 4'd3}, // R3
    '{1'b1, 8'd2, 4'h1, 32'h0000_00AA, 36'h0,           1'b1, 32'h0,         1'b0, 4'd4}, // R4
    '{1'b0, 8'd2, 4'h0, 32'h0,         36'h0,           1'b1, 32'h1234_56AA, 1'b0, 4'd4}, // R4
    '{1'b1, 8'd2, 4'hC, 32'hBEEF_0000, 36'h0,           1'b1, 32'h0,         1'b0, 4'd4}, // R4
    '{1'b0, 8'd2, 4'h0, 32'h0,         36'h0,           1'b1, 32'hBEEF_56AA, 1'b0, 4'd4}, // R4
    '{1'b0, 8'd1, 4'h0, 32'h0,         36'h0_0000_0001, 1'b1, 32'hA5A5_0F0E, 1'b1, 4'd5}, // R5
    '{1'b0, 8'd1, 4'h0, 32'h0,         36'h0,           1'b0, 32'hA5A5_0F0E, 1'b0, 4'd8}, // R8
    '{1'b1, 8'd1, 4'hF, 32'h0000_0001, 36'h0,           1'b1, 32'h0,         1'b0, 4'd3}, // R3 over bad word
    '{1'b0, 8'd1, 4'h0, 32'h0,         36'h0,           1'b1, 32'h0000_0001, 1'b0, 4'd3}, // R3
    '{1'b0, 8'd1, 4'h0, 32'h0,         36'h0_0100_0100, 1'b1, 32'h0100_0101, 1'b1, 4'd6}, // R6
    '{1'b1, 8'd1, 4'h2, 32'h0000_7700, 36'h0,           1'b1, 32'h0,         1'b1, 4'd7}, // R7
    '{1'b0, 8'd1, 4'h0, 32'h0,         36'h0,           1'b1, 32'h0100_7701, 1'b0, 4'd7}, // R7
    '{1'b0, 8'd3, 4'h0, 32'h0,         36'h8_0000_0000, 1'b1, 32'h0,         1'b1, 4'd5}, // R5 parity bit
    '{1'b1, 8'd3, 4'h4, 32'h0033_0000, 36'h0,           1'b0, 32'h0,         1'b0, 4'd8}, // R8
    '{1'b0, 8'd3, 4'h0, 32'h0,         36'h0,           1'b1, 32'h0033_0000, 1'b0, 4'd8}  // R8
  };

  logic          clk;
  logic          rst_n;
  logic          par_en;
  logic          bus_req;
  logic          bus_write;
  logic [AW-1:0] bus_addr;
  logic [3:0]    bus_strb;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata;
  logic          bus_ready;
  logic          bus_err;
  logic          mem_en;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [3:0]    mem_wpar;
  logic [DW-1:0] mem_rdata;
  logic [3:0]    mem_rpar;

  logic [35:0]   model [16];
  logic [35:0]   rdq;
  int            rd_cnt;
  int            wr_cnt;
  int            total;
  int            bad;
  bit            done;

  sram_parity_port #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .par_en    (par_en),
    .bus_req   (bus_req),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_strb  (bus_strb),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_ready (bus_ready),
    .bus_err   (bus_err),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_wpar  (mem_wpar),
    .mem_rdata (mem_rdata),
    .mem_rpar  (mem_rpar)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // SRAM model with one cycle read latency
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        model[mem_addr] <= {mem_wpar, mem_wdata};
        wr_cnt <= wr_cnt + 1;
      end else begin
        rdq <= model[mem_addr];
        rd_cnt <= rd_cnt + 1;
      end
    end
  end
  assign mem_rdata = rdq[31:0];
  assign mem_rpar  = rdq[35:32];

  function automatic logic [3:0] lane_par(logic [31:0] d);
    logic [3:0] p;
    for (int i = 0; i < 4; i++) p[i] = ^d[i*8 +: 8];
    return p;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_vec(vec_t v, int idx);
    int waited;
    int rd0;
    int wr0;
    string rq;
    logic [31:0] merged;
    rq = $sformatf("R%0d", v.req);
    @(negedge clk);
    model[v.addr[AW-1:0]] <= model[v.addr[AW-1:0]] ^ v.flip;
    par_en    = v.pen;
    bus_req   = 1'b1;
    bus_write = v.wr;
    bus_addr  = v.addr[AW-1:0];
    bus_strb  = v.strb;
    bus_wdata = v.wdata;
    rd0 = rd_cnt;
    wr0 = wr_cnt;
    waited = 0;
    do begin
      @(negedge clk);
      waited++;
    end while (!bus_ready && waited < 20);
    // R9: ready exactly one cycle after acceptance
    check("R9", 64'(waited), 64'd1, $sformatf("vec %0d ready latency", idx));
    check(rq, 64'(bus_err), 64'(v.exp_err), $sformatf("vec %0d bus_err", idx));
    if (!v.wr) check(rq, 64'(bus_rdata), 64'(v.exp_rd), $sformatf("vec %0d rdata", idx));
    bus_req = 1'b0;
    @(negedge clk);
    // R9: single-cycle ready, no stray error
    check("R9", 64'({bus_ready, bus_err}), 64'd0, $sformatf("vec %0d after response", idx));
    if (v.wr && v.strb == 4'hF) begin
      // R3: no read, one write, even parity per lane
      check("R3", 64'(rd_cnt - rd0), 64'd0, $sformatf("vec %0d reads", idx));
      check("R3", 64'(wr_cnt - wr0), 64'd1, $sformatf("vec %0d writes", idx));
      check("R3", 64'(model[v.addr[AW-1:0]][35:32]), 64'(lane_par(v.wdata)),
            $sformatf("vec %0d stored parity", idx));
    end else if (v.wr) begin
      // R4: one read then one write with parity of the stored merged word
      check("R4", 64'(rd_cnt - rd0), 64'd1, $sformatf("vec %0d reads", idx));
      check("R4", 64'(wr_cnt - wr0), 64'd1, $sformatf("vec %0d writes", idx));
      merged = model[v.addr[AW-1:0]][31:0];
      check("R4", 64'(model[v.addr[AW-1:0]][35:32]), 64'(lane_par(merged)),
            $sformatf("vec %0d stored parity", idx));
    end else begin
      check("R2", 64'(rd_cnt - rd0), 64'd1, $sformatf("vec %0d reads", idx));
      check("R2", 64'(wr_cnt - wr0), 64'd0, $sformatf("vec %0d writes", idx));
    end
  endtask

  initial begin
    total = 0; bad = 0; done = 1'b0;
    rd_cnt = 0; wr_cnt = 0;
    rdq = '0;
    for (int i = 0; i < 16; i++) model[i] <= '0;
    rst_n = 1'b0; par_en = 1'b1;
    bus_req = 1'b1; bus_write = 1'b1; bus_addr = '0; bus_strb = 4'hF; bus_wdata = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    // R1: held in reset despite a pending request
    check("R1", 64'({bus_ready, bus_err, mem_en}), 64'd0, "during reset");
    rst_n = 1'b1;
    @(negedge clk);
    // R1: synchronized release still gates the request
    check("R1", 64'({bus_ready, bus_err, mem_en}), 64'd0, "first cycle after release");
    bus_req = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", 64'(wr_cnt), 64'd0, "no write issued in reset");

    for (int k = 0; k < NV; k++) run_vec(VEC[k], k);

    // R8 corner: corrupt read with enable off, then same word with enable on
    run_vec('{1'b0, 8'd4, 4'h0, 32'h0, 36'h0_0000_0300, 1'b0, 32'h0000_0300, 1'b0, 4'd8}, 100);
    run_vec('{1'b0, 8'd4, 4'h0, 32'h0, 36'h0,           1'b1, 32'h0000_0300, 1'b0, 4'd6}, 101);
    // R7 corner: byte-0 write repairs lane 0 error; lane 1 untouched error is cleared by fresh parity
    run_vec('{1'b1, 8'd5, 4'h1, 32'h0000_0055, 36'h0_0000_0101, 1'b1, 32'h0, 1'b1, 4'd7}, 102);
    run_vec('{1'b0, 8'd5, 4'h0, 32'h0, 36'h0, 1'b1, 32'h0000_0155, 1'b0, 4'd7}, 103);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(100000 * 5);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule